// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside one bank of a synchronous DRAM core. It keeps the burst settings taken from a mode-register load and produces the column address for each beat of a read or write burst. A column command supplies the starting 9-bit column. The sequencer then presents one address per enabled clock until one of three things happens: the burst reaches its length, a burst-stop command arrives, or a new column command replaces it.

Two address orders are supported.

- **Sequential:** the low bits count upward and wrap inside the aligned block for the burst length.
- **Interleaved:** the low bits are the start column XORed with the beat number.

A full-page setting runs without a natural end. A single-location write setting shortens write bursts to one beat and leaves read bursts at the programmed length. When the clock enable is low, the block is frozen.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and right after it, `col_valid_o` is 0, `col_o` is 0, `cas_lat_o` is 2 and `mode_err_o` is 0. The default settings are 1 beat, sequential order, programmed-length writes.
- R2: Sequential order, with burst length BL = 2^n.
  - Beat k shows the start column with its low n bits replaced by (start + k) mod BL.
  - The upper bits stay fixed.
- R3: Interleaved order. The type bit is `mode_i[3]` = 1. Beat k shows the start column with its low n bits replaced by (start XOR k).
- R4: Length code and burst timing.
  - The length code is `mode_i[2:0]`: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8.
  - Beat 0 appears in the cycle after the command edge.
  - `col_valid_o` falls in the cycle after the last beat.
- R5: Length code 111 with `mode_i[3]` = 0 selects full page. The burst runs on past column 511, wraps to 0, and continues until it is stopped or interrupted.
- R6: The latency code is `mode_i[6:4]`. Code 010 sets `cas_lat_o` to 2 and code 011 sets it to 3.
- R7: A load with a reserved code sets `mode_err_o` and keeps all previous settings. The reserved codes are:
  - a length code of 100, 101 or 110;
  - length 111 together with the interleaved type;
  - any latency code other than 010 or 011;
  - `mode_i[8:7]` other than 00.
  
  A valid load clears `mode_err_o`.
- R8: With `mode_i[9]` = 1, a write burst has exactly one beat and a read burst keeps the programmed length. `burst_wr_o` is 1 on every beat of a write burst.
- R9: A burst-stop on an enabled edge ends the burst: `col_valid_o` is 0 in the next cycle.
- R10: A read or write command on an enabled edge abandons any running burst. Beat 0 of the new burst shows the new column in the next cycle.
- R11: While `cke_i` is 0, all outputs hold their values, and commands, stops and mode loads are ignored. The burst resumes with its next beat after `cke_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes the block |
| mode_load_i | input | 1 | Load the mode word |
| mode_i | input | 10 | Mode word: [2:0] length, [3] type, [6:4] latency, [8:7] op mode, [9] single write |
| rd_cmd_i | input | 1 | Read column command |
| wr_cmd_i | input | 1 | Write column command (takes precedence if both are set) |
| stop_i | input | 1 | Burst-stop command |
| col_i | input | 9 | Starting column of a command |
| col_o | output | 9 | Column address of the current beat (0 when idle) |
| col_valid_o | output | 1 | A beat is being presented |
| burst_wr_o | output | 1 | The current beat belongs to a write burst |
| cas_lat_o | output | 2 | Programmed read latency |
| mode_err_o | output | 1 | The last mode load carried a reserved code |

## Verification
A corrupted beat counter or captured start column shows up on `col_o` in the very next cycle, because every beat is exposed combinationally from the registers. A wrong captured length shows as `col_valid_o` staying high one cycle too long or falling one cycle too early. Bad mode decoding shows on `cas_lat_o` or `mode_err_o` one cycle after the load. A latched length fault becomes visible only at the end of the next burst, so every burst is run to completion and its end cycle is checked. Full page is checked across the 511-to-0 wrap.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;
  localparam int MODE_W     = 10;
  localparam int LG_W       = 4;
  localparam int MB_LEN     = 0;
  localparam int MB_TYPE    = 3;
  localparam int MB_CL      = 4;
  localparam int MB_OP      = 7;
  localparam int MB_WSINGLE = 9;

  typedef struct packed {
    logic [LG_W-1:0] len_lg;
    logic            full;
    logic            ilv;
    logic            wr_single;
    logic [1:0]      cas;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RST = '{len_lg: '0, full: 1'b0, ilv: 1'b0,
                                     wr_single: 1'b0, cas: 2'd2};
endpackage

// File: rtl/burst_mode_reg.sv
`timescale 1ns/1ps
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output burst_cfg_t        cfg_o,
  output logic              err_o
);
  burst_cfg_t cfg_q, nxt;
  logic       ok, err_q;

  always_comb begin
    ok            = 1'b1;
    nxt           = cfg_q;
    nxt.len_lg    = '0;
    nxt.full      = 1'b0;
    nxt.ilv       = mode_i[MB_TYPE];
    nxt.wr_single = mode_i[MB_WSINGLE];
    case (mode_i[MB_LEN +: 3])
      3'b000, 3'b001, 3'b010, 3'b011: nxt.len_lg = LG_W'(mode_i[MB_LEN +: 2]);
      3'b111: begin
        if (!mode_i[MB_TYPE]) begin
          nxt.full   = 1'b1;
          nxt.len_lg = LG_W'(COL_W);
        end else begin
          ok = 1'b0;
        end
      end
      default: ok = 1'b0;
    endcase
    case (mode_i[MB_CL +: 3])
      3'b010:  nxt.cas = 2'd2;
      3'b011:  nxt.cas = 2'd3;
      default: ok = 1'b0;
    endcase
    if (mode_i[MB_OP +: 2] != 2'b00) ok = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
    end else if (load_i) begin
      if (ok) begin
        cfg_q <= nxt;
        err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
module burst_beat_ctr
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             full_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o
);
  logic             active_q, full_q;
  logic [LG_W-1:0]  lg_q;
  logic [COL_W-1:0] beat_q, lim;

  assign lim = (COL_W'(1) << lg_q) - COL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      lg_q     <= '0;
      full_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      lg_q     <= lg_i;
      full_q   <= full_i;
    end else if (active_q && adv_i) begin
      if (stop_i || (!full_q && beat_q == lim)) active_q <= 1'b0;
      else                                     beat_q   <= beat_q + COL_W'(1);
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             ilv_i,
  input  logic             active_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] base_q, mask_q, low;
  logic             ilv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= col_i;
      mask_q <= (COL_W'(1) << lg_i) - COL_W'(1);
      ilv_q  <= ilv_i;
    end
  end

  // low bits wrap inside the aligned block; upper bits pass through
  assign low   = ilv_q ? (base_q ^ beat_i) : (base_q + beat_i);
  assign col_o = active_i ? ((base_q & ~mask_q) | (low & mask_q)) : '0;
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rd_cmd_i,
  input  logic              wr_cmd_i,
  input  logic              stop_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              burst_wr_o,
  output logic [1:0]        cas_lat_o,
  output logic              mode_err_o
);
  burst_cfg_t       cfg;
  logic             start, one_beat, active, wr_q;
  logic [LG_W-1:0]  eff_lg;
  logic [COL_W-1:0] beat;

  assign start    = cke_i & (rd_cmd_i | wr_cmd_i);
  assign one_beat = wr_cmd_i & cfg.wr_single;
  assign eff_lg   = one_beat ? '0 : cfg.len_lg;

  burst_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cke_i & mode_load_i),
    .mode_i (mode_i),
    .cfg_o  (cfg),
    .err_o  (mode_err_o)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (cke_i),
    .start_i  (start),
    .stop_i   (stop_i),
    .lg_i     (eff_lg),
    .full_i   (cfg.full & ~one_beat),
    .active_o (active),
    .beat_o   (beat)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .col_i    (col_i),
    .lg_i     (eff_lg),
    .ilv_i    (cfg.ilv),
    .active_i (active),
    .beat_i   (beat),
    .col_o    (col_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wr_q <= 1'b0;
    else if (start) wr_q <= wr_cmd_i;
  end

  assign col_valid_o = active;
  assign burst_wr_o  = active & wr_q;
  assign cas_lat_o   = cfg.cas;
endmodule

// File: rtl/burst_col_seq_chk.sv
`timescale 1ns/1ps
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_i,
  input logic             mode_load_i,
  input logic [3:0]       mode_len_i,
  input logic             rd_cmd_i,
  input logic             wr_cmd_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic [1:0]       cas_lat_o,
  input logic             mode_err_o
);
  logic len_rsv;
  assign len_rsv = mode_len_i[2] && !(mode_len_i[2:0] == 3'b111 && !mode_len_i[3]);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> (!col_valid_o && !mode_err_o));

  // R6
  cas_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_o == 2'd2 || cas_lat_o == 2'd3));

  // R7
  reserved_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && mode_load_i && len_rsv) |=> (mode_err_o && $stable(cas_lat_o)));

  // R9
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && stop_i && !rd_cmd_i && !wr_cmd_i) |=> !col_valid_o);

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && (rd_cmd_i || wr_cmd_i)) |=> (col_valid_o && col_o == $past(col_i)));

  // R11
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(col_o) && $stable(col_valid_o) && $stable(cas_lat_o) && $stable(mode_err_o)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .mode_load_i (mode_load_i),
  .mode_len_i  (mode_i[3:0]),
  .rd_cmd_i    (rd_cmd_i),
  .wr_cmd_i    (wr_cmd_i),
  .stop_i      (stop_i),
  .col_i       (col_i),
  .col_o       (col_o),
  .col_valid_o (col_valid_o),
  .cas_lat_o   (cas_lat_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke_i = 1'b1;
  logic       mode_load_i = 1'b0;
  logic [9:0] mode_i = '0;
  logic       rd_cmd_i = 1'b0;
  logic       wr_cmd_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [8:0] col_o;
  logic       col_valid_o, burst_wr_o, mode_err_o;
  logic [1:0] cas_lat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_col_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .mode_load_i(mode_load_i),
    .mode_i(mode_i), .rd_cmd_i(rd_cmd_i), .wr_cmd_i(wr_cmd_i), .stop_i(stop_i),
    .col_i(col_i), .col_o(col_o), .col_valid_o(col_valid_o),
    .burst_wr_o(burst_wr_o), .cas_lat_o(cas_lat_o), .mode_err_o(mode_err_o)
  );

  // {mode[9:0], wr, start[8:0], beats[10:0]}
  localparam int NV = 9;
  localparam logic [30:0] VEC [NV] = '{
    {10'h020, 1'b0, 9'h055, 11'd1},   // R4 BL1
    {10'h021, 1'b0, 9'h0FF, 11'd2},   // R2 BL2 wrap
    {10'h032, 1'b0, 9'h0A6, 11'd4},   // R2 BL4
    {10'h023, 1'b0, 9'h1FD, 11'd8},   // R2 BL8 top block
    {10'h02A, 1'b0, 9'h0E1, 11'd4},   // R3 BL4
    {10'h02B, 1'b0, 9'h013, 11'd8},   // R3 BL8
    {10'h029, 1'b1, 9'h101, 11'd2},   // R3 write BL2
    {10'h223, 1'b1, 9'h040, 11'd1},   // R8 single write
    {10'h223, 1'b0, 9'h040, 11'd8}    // R8 read keeps BL8
  };

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_mode(input logic [9:0] m);
    mode_load_i = 1'b1;
    mode_i = m;
    tick();
    mode_load_i = 1'b0;
  endtask

  task automatic issue(input bit w, input logic [8:0] c);
    rd_cmd_i = !w;
    wr_cmd_i = w;
    col_i = c;
    tick();
    rd_cmd_i = 1'b0;
    wr_cmd_i = 1'b0;
  endtask

  function automatic logic [8:0] exp_col(logic [8:0] s, int k, int n, bit ilv);
    logic [8:0] m;
    logic [8:0] kk;
    m = 9'(n - 1);
    kk = 9'(k);
    return ilv ? ((s & ~m) | ((s ^ kk) & m)) : ((s & ~m) | ((s + kk) & m));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick();
    // R1 during and after reset
    check_eq("R1 valid in reset", int'(col_valid_o), 0);
    check_eq("R1 col in reset", int'(col_o), 0);
    rst_ni = 1'b1;
    tick();
    check_eq("R1 cas default", int'(cas_lat_o), 2);
    check_eq("R1 err default", int'(mode_err_o), 0);
    check_eq("R1 valid after reset", int'(col_valid_o), 0);

    for (int v = 0; v < NV; v++) begin
      logic [9:0] m;
      bit         w;
      logic [8:0] s;
      int         n;
      string      tag;
      m = VEC[v][30:21];
      w = VEC[v][20];
      s = VEC[v][19:11];
      n = int'(VEC[v][10:0]);
      tag = m[9] ? "R8 beat" : (m[3] ? "R3 beat" : "R2 beat");
      load_mode(m);
      issue(w, s);
      for (int k = 0; k < n; k++) begin
        check_eq(tag, int'({col_valid_o, col_o}), int'({1'b1, exp_col(s, k, n, m[3])}));
        check_eq("R8 write flag", int'(burst_wr_o), int'(w));
        if (k < n - 1) tick();
      end
      tick();
      check_eq("R4 burst end", int'(col_valid_o), 0);
    end

    // R6 latency codes
    load_mode(10'h032);
    check_eq("R6 cas 3", int'(cas_lat_o), 3);
    load_mode(10'h020);
    check_eq("R6 cas 2", int'(cas_lat_o), 2);

    // R7 reserved codes keep previous settings (BL4, CL3)
    load_mode(10'h032);
    load_mode(10'h024);
    check_eq("R7 err len", int'(mode_err_o), 1);
    check_eq("R7 cas kept", int'(cas_lat_o), 3);
    issue(1'b0, 9'h000);
    for (int k = 0; k < 4; k++) begin
      check_eq("R7 old length beat", int'({col_valid_o, col_o}), int'({1'b1, 9'(k)}));
      tick();
    end
    check_eq("R7 old length end", int'(col_valid_o), 0);
    load_mode(10'h021);
    check_eq("R7 err cleared", int'(mode_err_o), 0);
    load_mode(10'h02F);
    check_eq("R7 err fullpage ilv", int'(mode_err_o), 1);
    load_mode(10'h042);
    check_eq("R7 err latency", int'(mode_err_o), 1);
    check_eq("R7 cas kept 2", int'(cas_lat_o), 2);
    load_mode(10'h0A2);
    check_eq("R7 err opmode", int'(mode_err_o), 1);

    // R5 full page wraps past 511
    load_mode(10'h027);
    check_eq("R5 load ok", int'(mode_err_o), 0);
    issue(1'b0, 9'h1FE);
    for (int k = 0; k < 514; k++) begin
      check_eq("R5 full page beat", int'({col_valid_o, col_o}), int'({1'b1, 9'(9'h1FE + 9'(k))}));
      tick();
    end
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    check_eq("R5 stopped", int'(col_valid_o), 0);

    // R9 stop mid burst
    load_mode(10'h023);
    issue(1'b0, 9'h080);
    tick();
    check_eq("R9 beat1", int'(col_o), 9'h081);
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    check_eq("R9 ended", int'(col_valid_o), 0);
    check_eq("R9 col idle", int'(col_o), 0);

    // R10 interrupt restarts at new column
    issue(1'b0, 9'h010);
    tick();
    check_eq("R10 old beat1", int'(col_o), 9'h011);
    issue(1'b0, 9'h033);
    for (int k = 0; k < 8; k++) begin
      check_eq("R10 new burst", int'({col_valid_o, col_o}), int'({1'b1, exp_col(9'h033, k, 8, 1'b0)}));
      tick();
    end
    check_eq("R10 end", int'(col_valid_o), 0);

    // R11 clock enable low freezes
    issue(1'b0, 9'h020);
    tick();
    check_eq("R11 pre beat", int'(col_o), 9'h021);
    cke_i = 1'b0;
    rd_cmd_i = 1'b1;
    col_i = 9'h100;
    mode_load_i = 1'b1;
    mode_i = 10'h032;
    stop_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check_eq("R11 frozen col", int'({col_valid_o, col_o}), int'({1'b1, 9'h021}));
      check_eq("R11 no load", int'(cas_lat_o), 2);
    end
    cke_i = 1'b1;
    rd_cmd_i = 1'b0;
    mode_load_i = 1'b0;
    stop_i = 1'b0;
    tick();
    check_eq("R11 resume", int'({col_valid_o, col_o}), int'({1'b1, 9'h022}));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule